// File: doc/BRIEF.md
# Microwire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM organised as 64 words. The host pulses a request with a 6-bit word address. The sequencer takes over the chip-select, clock and data-in pins and shifts out a 9-bit read command, most significant bit first: the opcode `110`, then the address. It then clocks in sixteen data bits, most significant first. To finish, it releases chip select and issues one more clock pulse. The word appears on `rd_data` with a one-cycle `done` pulse.

Every clock edge on the serial side is spaced by a programmable half-period of `half_div + 1` system cycles. The divider value is captured when a read starts. A full read therefore occupies exactly 53 half-periods.

While the sequencer is idle, software can drive the pins directly through a small control byte. Bit 0 is the serial clock, bit 1 is chip select, bit 2 is data-in, and bit 3 is a read-only copy of the data-out pin. This lets software bit-bang any other command.

Top module: `uwire_eeprom_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `rd_data` are all 0.
- R2: The command sent is `{3'b110, rd_addr}`, MSB first, one bit per rising edge of `ee_sk`. `ee_di` never changes while `ee_sk` is high.
- R3: In the first cycle of a read, `ee_cs` is 1 and `ee_sk` is 0. They stay that way for one half-period before the first rising clock edge.
- R4: The sixteen data bits are sampled MSB first, at the last cycle of each clock-high half-period. `done` is high for exactly one cycle, the first cycle with `busy` low, and `rd_data` then holds the word.
- R5: Every change of `ee_sk` during a read, the rise of `busy` and the fall of `busy` are each separated from the previous one by `half_div + 1` cycles. `busy` stays high for 53 × (`half_div + 1`) cycles.
- R6: A read produces 26 rising edges of `ee_sk`. The first 25 occur with `ee_cs` high. `ee_cs` falls in the same cycle as the 26th rise, and `ee_sk` then returns low.
- R7: `reg_rdata` shows `ee_sk` at bit 0, `ee_cs` at bit 1, `ee_di` at bit 2 and `ee_do` at bit 3, with bits 7:4 always 0.
- R8: While idle, `reg_wr` loads `reg_wdata[0]`, `reg_wdata[1]` and `reg_wdata[2]` into the clock, chip-select and data-in pins, visible from the next cycle.
- R9: While busy, `rd_req` and `reg_wr` have no effect. When `rd_req` and `reg_wr` arrive in the same idle cycle, the read wins and the write is dropped.
- R10: An `rd_req` in an idle cycle makes `busy` high from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | Half-period length minus one, in system cycles |
| rd_req | input | 1 | Start a word read (idle only) |
| rd_addr | input | ADDR_W | Word address to read |
| busy | output | 1 | Sequencer owns the pins |
| done | output | 1 | One-cycle pulse when `rd_data` is valid |
| rd_data | output | DATA_W | Word read from the EEPROM |
| reg_wr | input | 1 | Write the pin-control byte (idle only) |
| reg_wdata | input | 3 | Writable pin bits: clock, chip select, data-in |
| reg_rdata | output | 8 | Pin-control byte readback |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Some pin rules can be checked by assertions on every cycle:
- chip select rises with the clock low;
- data-in holds steady through each clock-high phase;
- no clock toggle comes sooner than one half-period after the last;
- chip select drops together with a clock rise;
- `done` follows the last busy cycle.

Other properties can only be shown by the bench's scenarios, which use a behavioural EEPROM model:
- the exact command word shifted out;
- the data value returned;
- the 26-edge count;
- the full 53-half-period length under several divider settings;
- the idle bit-bang path;
- the rejection of requests and writes made mid-read.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD_HI,
        ST_CMD_LO,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_END_HI,
        ST_END_LO
    } seq_st_e;

    localparam logic [2:0] READ_OPCODE = 3'b110;
    localparam int         OPCODE_W    = 3;

endpackage

// File: rtl/uwire_halfper_timer.sv
module uwire_halfper_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] load_val,
    output logic             expire
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == '0);

    // The count never rises except through a reload.
    AST_TMR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (cnt_q <= $past(cnt_q)))
        else $error("timer counted up without reload"); // R5

endmodule

// File: rtl/uwire_cmd_ser.sv
module uwire_cmd_ser #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = load_val;
        end else if (shift) begin
            sr_d = {sr_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb = sr_q[W-1];

endmodule

// File: rtl/uwire_data_des.sv
module uwire_data_des #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (sample) begin
            sr_d = {sr_q[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign word = sr_q;

endmodule

// File: rtl/uwire_eeprom_reader.sv
module uwire_eeprom_reader
    import uwire_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              reg_wr,
    input  logic [2:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);

    localparam int CMD_W   = OPCODE_W + ADDR_W;
    localparam int MAX_BIT = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W   = $clog2(MAX_BIT + 1);

    typedef struct packed {
        seq_st_e          st;
        logic             sk;
        logic             cs;
        logic             di;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_restart;
    logic [DIV_W-1:0] tmr_load;
    logic             tmr_expire;
    logic             cmd_load;
    logic             cmd_shift;
    logic             cmd_msb;
    logic             dat_sample;

    assign busy     = (ctl_q.st != ST_IDLE);
    assign tmr_load = busy ? ctl_q.div : half_div;

    uwire_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (tmr_restart),
        .load_val (tmr_load),
        .expire   (tmr_expire)
    );

    uwire_cmd_ser #(.W(CMD_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .load_val ({READ_OPCODE, rd_addr}),
        .shift    (cmd_shift),
        .msb      (cmd_msb)
    );

    uwire_data_des #(.W(DATA_W)) u_dat (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (dat_sample),
        .bit_in (ee_do),
        .word   (rd_data)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        tmr_restart = 1'b0;
        cmd_load    = 1'b0;
        cmd_shift   = 1'b0;
        dat_sample  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (rd_req) begin
                    ctl_d.st    = ST_SETUP;
                    ctl_d.cs    = 1'b1;
                    ctl_d.sk    = 1'b0;
                    ctl_d.di    = 1'b0;
                    ctl_d.cnt   = '0;
                    ctl_d.div   = half_div;
                    cmd_load    = 1'b1;
                    tmr_restart = 1'b1;
                end else if (reg_wr) begin
                    ctl_d.sk = reg_wdata[0];
                    ctl_d.cs = reg_wdata[1];
                    ctl_d.di = reg_wdata[2];
                end
            end
            ST_SETUP: begin
                if (tmr_expire) begin
                    ctl_d.st    = ST_CMD_HI;
                    ctl_d.sk    = 1'b1;
                    tmr_restart = 1'b1;
                end
            end
            ST_CMD_HI: begin
                if (tmr_expire) begin
                    ctl_d.st    = ST_CMD_LO;
                    ctl_d.sk    = 1'b0;
                    ctl_d.cnt   = ctl_q.cnt + 1'b1;
                    cmd_shift   = 1'b1;
                    tmr_restart = 1'b1;
                end
            end
            ST_CMD_LO: begin
                if (tmr_expire) begin
                    ctl_d.sk    = 1'b1;
                    tmr_restart = 1'b1;
                    if (ctl_q.cnt == CNT_W'(CMD_W)) begin
                        ctl_d.st  = ST_DAT_HI;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.st = ST_CMD_HI;
                    end
                end
            end
            ST_DAT_HI: begin
                if (tmr_expire) begin
                    ctl_d.st    = ST_DAT_LO;
                    ctl_d.sk    = 1'b0;
                    ctl_d.cnt   = ctl_q.cnt + 1'b1;
                    dat_sample  = 1'b1;
                    tmr_restart = 1'b1;
                end
            end
            ST_DAT_LO: begin
                if (tmr_expire) begin
                    ctl_d.sk    = 1'b1;
                    tmr_restart = 1'b1;
                    if (ctl_q.cnt == CNT_W'(DATA_W)) begin
                        ctl_d.st = ST_END_HI;
                        ctl_d.cs = 1'b0;
                    end else begin
                        ctl_d.st = ST_DAT_HI;
                    end
                end
            end
            ST_END_HI: begin
                if (tmr_expire) begin
                    ctl_d.st    = ST_END_LO;
                    ctl_d.sk    = 1'b0;
                    tmr_restart = 1'b1;
                end
            end
            ST_END_LO: begin
                if (tmr_expire) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, sk: 1'b0, cs: 1'b0, di: 1'b0,
                       cnt: '0, div: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done      = ctl_q.done;
    assign ee_sk     = ctl_q.sk;
    assign ee_cs     = ctl_q.cs;
    assign ee_di     = busy ? cmd_msb : ctl_q.di;
    assign reg_rdata = {4'b0000, ee_do, ee_di, ee_cs, ee_sk};

    // Cycles since the serial clock last changed, saturating.
    logic [DIV_W:0] gap_q;
    logic           sk_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            sk_prev_q <= 1'b0;
        end else begin
            sk_prev_q <= ee_sk;
            if (ee_sk != sk_prev_q) begin
                gap_q <= '0;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_START_CS_LOW_SK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ee_cs && !ee_sk))
        else $error("read began without cs high and sk low"); // R3

    AST_DI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ee_sk && $past(ee_sk)) |-> $stable(ee_di))
        else $error("di moved while sk high"); // R2

    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (ee_sk != sk_prev_q)) |-> (gap_q >= {1'b0, ctl_q.div}))
        else $error("sk toggled before half-period elapsed"); // R5

    AST_CS_DROP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(ee_cs)) |-> ee_sk)
        else $error("cs released without trailing clock"); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)))
        else $error("done outside end of read"); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle"); // R4

    AST_REQ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy) |=> busy)
        else $error("idle request not accepted"); // R10

endmodule

// File: tb/uwire_eeprom_reader_test.sv
module uwire_eeprom_reader_test;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DIV_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  half_div = '0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] rd_data;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              ee_cs;
    logic              ee_sk;
    logic              ee_di;
    logic              ee_do = 1'b0;

    int vectors = 0;
    int fails   = 0;
    bit finished = 1'b0;

    uwire_eeprom_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_div  (half_div),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di),
        .ee_do     (ee_do)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] ee_word(input logic [5:0] a);
        return 16'hB5A3 ^ {a, a[5:2], ~a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
        chk("R1 busy/done", {30'd0, busy, done}, 32'd0);
        chk("R1 rd_data", {16'd0, rd_data}, 32'd0);
    endtask

    task automatic test_bitbang();
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 3'b101;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 pins after write 101", {29'd0, ee_di, ee_cs, ee_sk}, 32'b101);
        ee_do = 1'b1;
        #1;
        chk("R7 readback with do=1", {24'd0, reg_rdata}, 32'h0D);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 3'b010;
        @(negedge clk);
        reg_wr = 1'b0; ee_do = 1'b0;
        #1;
        chk("R7 R8 readback cs only", {24'd0, reg_rdata}, 32'h02);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 3'b000;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 pins cleared", {29'd0, ee_di, ee_cs, ee_sk}, 32'd0);
    endtask

    task automatic do_read(input logic [5:0] addr, input int div,
                           input bit inject, input bit same_wr);
        logic [15:0] word;
        logic [8:0]  cmd;
        int d, cyc, last, k, term, busy_cyc, gaps_bad, di_bad;
        logic prev_sk, prev_di;
        word = ee_word(addr);
        d = div + 1;
        @(negedge clk);
        half_div = DIV_W'(div);
        rd_addr  = addr;
        rd_req   = 1'b1;
        reg_wr   = same_wr;
        reg_wdata = 3'b111;
        @(negedge clk);
        rd_req = 1'b0;
        reg_wr = 1'b0;
        chk("R10 busy after request", {31'd0, busy}, 32'd1);
        chk("R3 cs high sk low at start", {30'd0, ee_cs, ee_sk}, 32'b10);
        if (same_wr) chk("R9 read beats same-cycle write", {31'd0, ee_sk}, 32'd0);
        cyc = 0; last = 0; k = 0; term = 0; cmd = '0;
        busy_cyc = 1; gaps_bad = 0; di_bad = 0;
        prev_sk = ee_sk; prev_di = ee_di;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 7) begin
                rd_req = 1'b1; rd_addr = addr ^ 6'h3F;
                reg_wr = 1'b1; reg_wdata = 3'b000;
            end else if (inject && cyc == 8) begin
                rd_req = 1'b0; reg_wr = 1'b0;
            end
            if (!busy) break;
            busy_cyc++;
            if (ee_sk && prev_sk && (ee_di !== prev_di)) di_bad++;
            if (ee_sk !== prev_sk) begin
                if ((cyc - last) != d) gaps_bad++;
                last = cyc;
                if (ee_sk) begin
                    if (ee_cs) begin
                        k++;
                        if (k <= 9) cmd = {cmd[7:0], ee_di};
                        if (k >= 10 && k <= 25) ee_do = word[25-k];
                    end else begin
                        term++;
                    end
                end
            end
            prev_sk = ee_sk;
            prev_di = ee_di;
        end
        chk("R5 busy fall spacing", cyc - last, d);
        chk("R5 R10 busy length", busy_cyc, 53 * d);
        chk("R5 sk edge spacing errors", gaps_bad, 0);
        chk("R2 command word", {23'd0, cmd}, {23'd0, 3'b110, addr});
        chk("R2 di steady while sk high", di_bad, 0);
        chk("R6 rises with cs", k, 25);
        chk("R6 trailing rise without cs", term, 1);
        chk("R6 pins low at end", {30'd0, ee_cs, ee_sk}, 32'd0);
        chk("R4 done pulse", {31'd0, done}, 32'd1);
        chk("R4 rd_data", {16'd0, rd_data}, {16'd0, word});
        ee_do = 1'b0;
        @(negedge clk);
        chk("R4 done single cycle", {31'd0, done}, 32'd0);
        if (inject) chk("R9 no second read started", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_bitbang();
        do_read(6'd2, 0, 1'b0, 1'b0);
        do_read(6'd63, 3, 1'b0, 1'b0);
        do_read(6'd0, 1, 1'b1, 1'b0);
        do_read(6'h15, 2, 1'b0, 1'b1);
        test_bitbang();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule